// File: doc/BRIEF.md
# Reset-Strapped Bus Cycle Terminator

This block is the cycle-termination unit of a bus master. Two strap inputs are read while reset is held low. They fix, until the next reset, which termination encoding the slave side uses and whether written data is held on the bus one extra clock. Once a cycle is launched, the unit samples the acknowledge, error and retry inputs on every rising clock edge of the sampling window. Each sample is classified as wait, normal end, error or retry.

The unit runs single transfers and four-beat line bursts. It drives the data-bus output enable for writes and reloads the outgoing data word at the start of each beat. When extra hold is on, it inserts a dead clock between write burst beats, so a zero-wait write burst cannot occur. Read cycles run identically in both hold settings. An error or retry aborts the cycle at once and reports the outcome on a status code that holds until the next cycle ends.

Top module: `bus_cycle_term`

## Requirements
- R1: `cfgNative` and `cfgHold` take the values of `strapNative` and `strapHold` from the last rising clock at which `rstN` was low, and they stay constant while `rstN` is high.
- R2: After reset `busy`, `dataOe`, `beatDone` and `cycleDone` are 0, and `status` and `dataOut` are 0.
- R3: In legacy mode (`cfgNative`=0) a sample with `tAck` and `tErr` both high is a retry, `tErr` alone is an error, and `tAck` alone is a normal end. `status` encodes 0 as normal, 1 as error and 2 as retry.
- R4: In legacy mode `tRetry` has no effect on classification.
- R5: In native mode (`cfgNative`=1), `tRetry` high is a retry whatever the other inputs are. Otherwise `tErr` is an error, and `tAck` alone is a normal end.
- R6: Termination inputs affect nothing outside the sampling window. Idle clocks, the write hold clock and the burst gap clock are outside the window. A window sample with none of the three inputs high is a wait.
- R7: `cycleStart` in an idle clock opens the sampling window from the next clock. A single transfer ends on its first normal end. A burst (`cycleBurst`=1) ends after its fourth normal end. `busy` is high from the clock after the start until the cycle is over.
- R8: An error or retry ends the cycle at the sampled edge, even mid-burst. `cycleDone` then pulses for one clock with `status` 1 or 2, and `busy` drops at that same edge.
- R9: For a write, `dataOe` is high while `busy` is high. Without extra hold it falls at the edge of the final normal end. With extra hold it stays high for exactly one more clock.
- R10: For a read, `dataOe` stays 0. Read timing is identical with extra hold on or off.
- R11: `beatDone` pulses once per normal end. For a write burst with extra hold, each non-final beat is followed by one gap clock before the next sample.
- R12: `dataOut` loads `wrData` at the edge that begins each beat's sampling window: the start edge, a non-final beat edge without a gap, and a gap exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapNative | input | 1 | Strap: native termination encoding |
| strapHold | input | 1 | Strap: extra write hold |
| cycleStart | input | 1 | Launch a bus cycle (idle only) |
| cycleWrite | input | 1 | Cycle is a write |
| cycleBurst | input | 1 | Cycle is a four-beat burst |
| wrData | input | DATA_W | Write data for the current beat |
| tAck | input | 1 | Transfer acknowledge, active high |
| tErr | input | 1 | Transfer error, active high |
| tRetry | input | 1 | Dedicated retry, active high |
| busy | output | 1 | Cycle in progress |
| dataOe | output | 1 | Data bus drive enable |
| dataOut | output | DATA_W | Data driven on the bus |
| beatDone | output | 1 | Pulse per normally ended beat |
| cycleDone | output | 1 | Pulse when a cycle ends |
| status | output | 2 | Last cycle outcome: 0 normal, 1 error, 2 retry |
| cfgNative | output | 1 | Latched encoding select |
| cfgHold | output | 1 | Latched hold select |

## Verification
The bench targets the overlap cases of the two encodings. In legacy mode, acknowledge plus error must read as retry and a stray retry input must be ignored. In native mode, retry must win over error, and error over acknowledge. A swapped priority would show a wrong status code or a burst that continues. It also drives acknowledge through idle, hold and gap clocks. A design that samples there would end cycles early or count extra beats. Write bursts with extra hold and a continuously asserted acknowledge expose a missing gap clock as back-to-back beat pulses. A missing or doubled hold clock shows up in the drive-enable timing. Strap inputs are toggled after reset to show that the latched configuration does not follow them.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [1:0] {
    TERM_WAIT  = 2'd0,
    TERM_OK    = 2'd1,
    TERM_ERR   = 2'd2,
    TERM_RETRY = 2'd3
  } term_e;

  localparam logic [1:0] STS_OK    = 2'd0;
  localparam logic [1:0] STS_ERR   = 2'd1;
  localparam logic [1:0] STS_RETRY = 2'd2;

  typedef struct packed {
    logic       loadData;
    logic       beatPulse;
    logic       endPulse;
    logic [1:0] endCode;
  } strobe_t;
endpackage

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
(
  input  logic  sampleEn,
  input  logic  native,
  input  logic  ack,
  input  logic  err,
  input  logic  retry,
  output term_e term
);
  always_comb begin
    term = TERM_WAIT;
    if (sampleEn) begin
      if (native) begin
        if (retry)    term = TERM_RETRY;
        else if (err) term = TERM_ERR;
        else if (ack) term = TERM_OK;
      end else begin
        // legacy encoding: the dedicated retry line is not looked at
        if (ack && err) term = TERM_RETRY;
        else if (err)   term = TERM_ERR;
        else if (ack)   term = TERM_OK;
      end
    end
  end
endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl
  import bct_pkg::*;
#(
  parameter int BEAT_COUNT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycleStart,
  input  logic    cycleWrite,
  input  logic    cycleBurst,
  input  logic    holdCfg,
  input  term_e   term,
  output strobe_t stb,
  output logic    sampleEn,
  output logic    busy,
  output logic    dataOe
);
  localparam int BEAT_W = (BEAT_COUNT > 1) ? $clog2(BEAT_COUNT) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEAT_COUNT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_HOLD, ST_GAP} state_e;

  state_e            state, stateNext;
  logic              wrQ, burstQ;
  logic [BEAT_W-1:0] beatQ, beatNext;
  logic              lastBeat;

  assign lastBeat = !burstQ || (beatQ == LAST_BEAT);
  assign sampleEn = (state == ST_SAMPLE);
  assign busy     = (state != ST_IDLE);
  assign dataOe   = wrQ && busy;

  always_comb begin
    stateNext = state;
    beatNext  = beatQ;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (cycleStart) begin
          stateNext    = ST_SAMPLE;
          beatNext     = '0;
          stb.loadData = 1'b1;
        end
      end
      ST_SAMPLE: begin
        unique case (term)
          TERM_OK: begin
            stb.beatPulse = 1'b1;
            if (lastBeat) begin
              stb.endPulse = 1'b1;
              stb.endCode  = STS_OK;
              stateNext    = (wrQ && holdCfg) ? ST_HOLD : ST_IDLE;
            end else begin
              beatNext = beatQ + 1'b1;
              if (wrQ && holdCfg) stateNext = ST_GAP;
              else                stb.loadData = 1'b1;
            end
          end
          TERM_ERR: begin
            stb.endPulse = 1'b1;
            stb.endCode  = STS_ERR;
            stateNext    = ST_IDLE;
          end
          TERM_RETRY: begin
            stb.endPulse = 1'b1;
            stb.endCode  = STS_RETRY;
            stateNext    = ST_IDLE;
          end
          default: ;
        endcase
      end
      ST_HOLD: stateNext = ST_IDLE;
      ST_GAP: begin
        stateNext    = ST_SAMPLE;
        stb.loadData = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      beatQ  <= '0;
      wrQ    <= 1'b0;
      burstQ <= 1'b0;
    end else begin
      state <= stateNext;
      beatQ <= beatNext;
      if (state == ST_IDLE && cycleStart) begin
        wrQ    <= cycleWrite;
        burstQ <= cycleBurst;
      end
    end
  end
endmodule

// File: rtl/bct_datapath.sv
module bct_datapath
  import bct_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapNative,
  input  logic              strapHold,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           stb,
  output logic              cfgNative,
  output logic              cfgHold,
  output logic [DATA_W-1:0] dataOut,
  output logic              beatDone,
  output logic              cycleDone,
  output logic [1:0]        status
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgNative <= strapNative;
      cfgHold   <= strapHold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      beatDone  <= 1'b0;
      cycleDone <= 1'b0;
      status    <= STS_OK;
    end else begin
      beatDone  <= stb.beatPulse;
      cycleDone <= stb.endPulse;
      if (stb.endPulse) status  <= stb.endCode;
      if (stb.loadData) dataOut <= wrData;
    end
  end
endmodule

// File: rtl/bus_cycle_term.sv
module bus_cycle_term
  import bct_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BEAT_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapNative,
  input  logic              strapHold,
  input  logic              cycleStart,
  input  logic              cycleWrite,
  input  logic              cycleBurst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tAck,
  input  logic              tErr,
  input  logic              tRetry,
  output logic              busy,
  output logic              dataOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              beatDone,
  output logic              cycleDone,
  output logic [1:0]        status,
  output logic              cfgNative,
  output logic              cfgHold
);
  strobe_t stb;
  term_e   term;
  logic    sampleEn;

  bct_decode u_decode (
    .sampleEn (sampleEn),
    .native   (cfgNative),
    .ack      (tAck),
    .err      (tErr),
    .retry    (tRetry),
    .term     (term)
  );

  bct_ctrl #(.BEAT_COUNT(BEAT_COUNT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .cycleWrite (cycleWrite),
    .cycleBurst (cycleBurst),
    .holdCfg    (cfgHold),
    .term       (term),
    .stb        (stb),
    .sampleEn   (sampleEn),
    .busy       (busy),
    .dataOe     (dataOe)
  );

  bct_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strapNative (strapNative),
    .strapHold   (strapHold),
    .wrData      (wrData),
    .stb         (stb),
    .cfgNative   (cfgNative),
    .cfgHold     (cfgHold),
    .dataOut     (dataOut),
    .beatDone    (beatDone),
    .cycleDone   (cycleDone),
    .status      (status)
  );
endmodule

// File: rtl/bct_checker.sv
module bct_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       dataOe,
  input logic       beatDone,
  input logic       cycleDone,
  input logic [1:0] status,
  input logic       cfgNative,
  input logic       cfgHold
);
  a_r1_cfg_stable: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(cfgNative) && $stable(cfgHold)));

  a_r9_oe_within_cycle: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> busy);

  a_r8_abort_goes_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && status != 2'd0) |-> !busy);

  a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  a_r9_no_hold_release: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && status == 2'd0 && !cfgHold) |-> !dataOe);

  a_r9_hold_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && status == 2'd0 && dataOe) |=> !busy);

  a_r11_write_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHold && dataOe && beatDone) |=> !beatDone);
endmodule

bind bus_cycle_term bct_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .dataOe    (dataOe),
  .beatDone  (beatDone),
  .cycleDone (cycleDone),
  .status    (status),
  .cfgNative (cfgNative),
  .cfgHold   (cfgHold)
);

// File: tb/bus_cycle_term_tb.sv
module bus_cycle_term_tb;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapNative = 1'b0, strapHold = 1'b0;
  logic cycleStart = 1'b0, cycleWrite = 1'b0, cycleBurst = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic tAck = 1'b0, tErr = 1'b0, tRetry = 1'b0;
  logic busy, dataOe, beatDone, cycleDone, cfgNative, cfgHold;
  logic [DW-1:0] dataOut;
  logic [1:0] status;

  always #4 clk = ~clk;

  bus_cycle_term #(.DATA_W(DW), .BEAT_COUNT(4)) u_dut (
    .clk(clk), .rstN(rstN), .strapNative(strapNative), .strapHold(strapHold),
    .cycleStart(cycleStart), .cycleWrite(cycleWrite), .cycleBurst(cycleBurst),
    .wrData(wrData), .tAck(tAck), .tErr(tErr), .tRetry(tRetry),
    .busy(busy), .dataOe(dataOe), .dataOut(dataOut), .beatDone(beatDone),
    .cycleDone(cycleDone), .status(status), .cfgNative(cfgNative), .cfgHold(cfgHold)
  );

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R2";

  // reference model state: 0 idle, 1 sampling, 2 hold, 3 gap
  int mSt = 0, mBeat = 0;
  logic mWr = 0, mBurst = 0, mDone = 0, mBeatDone = 0, mNative = 0, mHold = 0;
  logic [1:0] mStatus = 0;
  logic [DW-1:0] mData = 0;

  // 0 wait, 1 normal, 2 error, 3 retry
  function automatic int classify(logic nat, logic a, logic e, logic r);
    if (nat) return r ? 3 : (e ? 2 : (a ? 1 : 0));
    return (a && e) ? 3 : (e ? 2 : (a ? 1 : 0));
  endfunction

  task automatic modelStep();
    int c;
    if (!rstN) begin
      mNative = strapNative; mHold = strapHold;
      mSt = 0; mBeat = 0; mWr = 0; mBurst = 0;
      mDone = 0; mBeatDone = 0; mStatus = 0; mData = 0;
      return;
    end
    mDone = 0; mBeatDone = 0;
    case (mSt)
      0: if (cycleStart) begin
           mSt = 1; mWr = cycleWrite; mBurst = cycleBurst; mBeat = 0; mData = wrData;
         end
      1: begin
           c = classify(mNative, tAck, tErr, tRetry);
           if (c == 1) begin
             mBeatDone = 1;
             if (!mBurst || mBeat == 3) begin
               mDone = 1; mStatus = 0; mSt = (mWr && mHold) ? 2 : 0;
             end else begin
               mBeat++;
               if (mWr && mHold) mSt = 3; else mData = wrData;
             end
           end else if (c >= 2) begin
             mDone = 1; mStatus = (c == 2) ? 2'd1 : 2'd2; mSt = 0;
           end
         end
      2: mSt = 0;
      default: begin mSt = 1; mData = wrData; end
    endcase
  endtask

  task automatic chk(string req, string sig, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) %s got %0h exp %0h t=%0t", req, phase, sig, act, exp, $time);
    end
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    chk("R7", "busy", busy, mSt != 0);
    chk("R9", "dataOe", dataOe, mWr && mSt != 0);
    chk("R8", "cycleDone", cycleDone, mDone);
    chk("R11", "beatDone", beatDone, mBeatDone);
    chk("R3", "status", status, mStatus);
    chk("R12", "dataOut", dataOut, mData);
    chk("R1", "cfgNative", cfgNative, mNative);
    chk("R1", "cfgHold", cfgHold, mHold);
  endtask

  task automatic doReset(logic nat, logic hold);
    rstN = 0; strapNative = nat; strapHold = hold;
    cycleStart = 0; tAck = 0; tErr = 0; tRetry = 0;
    tick(); tick();
    rstN = 1; strapNative = ~nat; strapHold = ~hold;   // straps move after reset (R1)
    tick();
  endtask

  task automatic issue(logic wr, logic burst, logic [DW-1:0] d);
    cycleStart = 1; cycleWrite = wr; cycleBurst = burst; wrData = d;
    tick();
    cycleStart = 0;
  endtask

  task automatic resp(logic a, logic e, logic r);
    tAck = a; tErr = e; tRetry = r;
    tick();
    tAck = 0; tErr = 0; tRetry = 0;
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    phase = "R2"; doReset(1'b0, 1'b0);
    phase = "R1"; tick();

    phase = "R3";
    issue(0, 0, 32'h11); resp(1, 1, 0); tick();
    issue(0, 0, 32'h12); resp(0, 1, 0); tick();
    issue(1, 0, 32'h13); resp(0, 0, 0); resp(1, 0, 0); tick();

    phase = "R4";
    issue(0, 0, 32'h21); resp(0, 0, 1); resp(1, 0, 1); tick();

    phase = "R6";
    resp(1, 1, 1); resp(1, 0, 0);
    issue(0, 1, 32'h31); resp(1, 0, 0); resp(0, 0, 0); resp(1, 0, 0); resp(1, 0, 0); resp(1, 0, 0); tick();

    phase = "R5"; doReset(1'b1, 1'b0);
    issue(0, 0, 32'h41); resp(0, 0, 1); tick();
    issue(0, 0, 32'h42); resp(1, 1, 1); tick();
    issue(0, 0, 32'h43); resp(1, 1, 0); tick();
    issue(0, 0, 32'h44); resp(1, 0, 0); tick();

    phase = "R8";
    issue(1, 1, 32'h51); resp(1, 0, 0); resp(0, 1, 0); tick();
    issue(0, 1, 32'h52); resp(1, 0, 0); resp(1, 0, 0); resp(0, 0, 1); tick();

    phase = "R12";
    issue(1, 1, 32'hA0);
    for (int b = 0; b < 4; b++) begin wrData = 32'hA1 + b; resp(1, 0, 0); end
    tick();

    phase = "R9"; doReset(1'b0, 1'b1);
    issue(1, 0, 32'h61); resp(0, 0, 0); resp(1, 0, 0); tick(); tick();

    phase = "R11";
    issue(1, 1, 32'h71); tAck = 1;
    for (int k = 0; k < 10; k++) begin wrData = 32'h72 + k; tick(); end
    tAck = 0; tick(); tick();

    phase = "R10";
    issue(0, 1, 32'h81); tAck = 1; for (int k = 0; k < 4; k++) tick(); tAck = 0; tick();

    phase = "R7";
    for (int m = 0; m < 4; m++) begin
      doReset(m[0], m[1]);
      for (int n = 0; n < 1500; n++) begin
        int p;
        cycleStart = ($urandom % 3) == 0;
        cycleWrite = $urandom % 2;
        cycleBurst = $urandom % 2;
        wrData = $urandom;
        p = $urandom % 16;
        tAck = p < 9; tErr = p == 9 || p == 10; tRetry = p == 11 || p == 12;
        tick();
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule